// File: doc/BRIEF.md
# Dual-Source Receive Byte Queue

This block buffers bytes arriving from two producers, a keyboard source and an auxiliary (pointing-device) source. Each producer has its own circular queue. A single consumer pulls bytes through one data port. Each queue has its own read pointer, write pointer and occupancy count.

The next byte is always on `rd_data_o`, and asserting `rd_i` for one clock consumes it. The keyboard queue is always served first. The auxiliary queue is served only while the keyboard queue is empty. When both queues are empty, the port keeps showing the keyboard byte consumed most recently, and a read changes nothing. That byte is the keyboard slot just behind the read pointer. Two outputs tell the consumer whether data is waiting and which source the next read will take it from.

Top module: `kbd_aux_rx_queue`

## Requirements
- R1: While the keyboard queue holds data, `rd_data_o` shows its oldest byte. A read removes that byte and leaves the auxiliary queue untouched.
- R2: When the keyboard queue is empty and the auxiliary queue holds data, `rd_data_o` shows the oldest auxiliary byte, and a read removes it.
- R3: When both queues are empty, `rd_data_o` shows the keyboard slot one position before the keyboard read pointer, wrapping to slot DEPTH-1 at pointer 0. This is the last keyboard byte consumed, or 0x00 if none has been consumed since reset. A read in this state changes no pointer and no count.
- R4: Each queue returns bytes in arrival order, and its pointers wrap from DEPTH-1 to 0. Order is kept across any number of wraps.
- R5: A push into a queue that already holds DEPTH bytes is dropped, and that byte never appears on `rd_data_o`. The full test uses the occupancy before the clock edge, even when a read of the same queue happens in that cycle.
- R6: `avail_o` is 1 exactly when at least one queue holds data.
- R7: `avail_aux_o` is 1 exactly when the keyboard queue is empty and the auxiliary queue holds data.
- R8: A push and a read of the same non-full queue in one cycle both take effect, and the count is unchanged.
- R9: After reset both queues are empty, `avail_o` and `avail_aux_o` are 0, and `rd_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kbd_push_i | input | 1 | Write `kbd_data_i` into the keyboard queue |
| kbd_data_i | input | DATA_W | Keyboard byte |
| aux_push_i | input | 1 | Write `aux_data_i` into the auxiliary queue |
| aux_data_i | input | DATA_W | Auxiliary byte |
| rd_i | input | 1 | Consume the byte shown on `rd_data_o` |
| rd_data_o | output | DATA_W | Byte a read returns this cycle |
| avail_o | output | 1 | At least one queue holds data |
| avail_aux_o | output | 1 | Next read is served from the auxiliary queue |

## Verification
The bench builds the block with DEPTH = 4, so a few pushes fill a queue and a few reads wrap its pointers. That makes the dropped-push rule and the replay from the slot before pointer 0 reachable many times in each run. The stimulus moves through phases with different push and read rates. These phases alternate between long stretches with both queues empty (replay), keyboard bursts that starve the auxiliary queue, and saturation with simultaneous push and read.

// File: rtl/kbdq_pkg.sv
package kbdq_pkg;
  typedef enum logic [0:0] {
    SRC_KBD = 1'b0,
    SRC_AUX = 1'b1
  } kbdq_src_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/kbdq_ring.sv
module kbdq_ring #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [DATA_W-1:0] prev_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rptr_q, wptr_q, prev_idx;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // full test on pre-edge occupancy
  assign do_push  = push_i && (cnt_q != FULL);
  assign do_pop   = pop_i && (cnt_q != '0);
  assign prev_idx = (rptr_q == '0) ? LAST : rptr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= data_i;
        wptr_q        <= step(wptr_q);
      end
      if (do_pop) rptr_q <= step(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = mem_q[rptr_q];
  assign prev_o = mem_q[prev_idx];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/kbdq_sel.sv
module kbdq_sel
  import kbdq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rd_i,
  input  logic              kbd_nz_i,
  input  logic              aux_nz_i,
  input  logic [DATA_W-1:0] kbd_head_i,
  input  logic [DATA_W-1:0] kbd_prev_i,
  input  logic [DATA_W-1:0] aux_head_i,
  output logic              kbd_pop_o,
  output logic              aux_pop_o,
  output logic [DATA_W-1:0] data_o,
  output kbdq_src_e         src_o,
  output logic              avail_o
);
  always_comb begin
    kbd_pop_o = 1'b0;
    aux_pop_o = 1'b0;
    src_o     = SRC_KBD;
    if (kbd_nz_i) begin
      data_o    = kbd_head_i;
      kbd_pop_o = rd_i;
    end else if (aux_nz_i) begin
      data_o    = aux_head_i;
      aux_pop_o = rd_i;
      src_o     = SRC_AUX;
    end else begin
      data_o = kbd_prev_i;  // replay, no state change
    end
  end

  assign avail_o = kbd_nz_i | aux_nz_i;
endmodule

// File: rtl/kbd_aux_rx_queue.sv
module kbd_aux_rx_queue
  import kbdq_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kbd_push_i,
  input  logic [DATA_W-1:0] kbd_data_i,
  input  logic              aux_push_i,
  input  logic [DATA_W-1:0] aux_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              avail_o,
  output logic              avail_aux_o
);
  logic              push   [NUM_SRC];
  logic [DATA_W-1:0] wdata  [NUM_SRC];
  logic              pop    [NUM_SRC];
  logic [DATA_W-1:0] head   [NUM_SRC];
  logic [DATA_W-1:0] prev   [NUM_SRC];
  logic [CNT_W-1:0]  cnt    [NUM_SRC];
  logic [CNT_W-1:0]  kbd_cnt, aux_cnt;
  logic              kbd_pop, aux_pop;
  kbdq_src_e         src;

  assign push[SRC_KBD]  = kbd_push_i;
  assign push[SRC_AUX]  = aux_push_i;
  assign wdata[SRC_KBD] = kbd_data_i;
  assign wdata[SRC_AUX] = aux_data_i;
  assign pop[SRC_KBD]   = kbd_pop;
  assign pop[SRC_AUX]   = aux_pop;
  assign kbd_cnt        = cnt[SRC_KBD];
  assign aux_cnt        = cnt[SRC_AUX];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ring
    kbdq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push[g]),
      .data_i (wdata[g]),
      .pop_i  (pop[g]),
      .head_o (head[g]),
      .prev_o (prev[g]),
      .cnt_o  (cnt[g])
    );
  end

  kbdq_sel #(.DATA_W(DATA_W)) u_sel (
    .rd_i       (rd_i),
    .kbd_nz_i   (kbd_cnt != '0),
    .aux_nz_i   (aux_cnt != '0),
    .kbd_head_i (head[SRC_KBD]),
    .kbd_prev_i (prev[SRC_KBD]),
    .aux_head_i (head[SRC_AUX]),
    .kbd_pop_o  (kbd_pop),
    .aux_pop_o  (aux_pop),
    .data_o     (rd_data_o),
    .src_o      (src),
    .avail_o    (avail_o)
  );

  assign avail_aux_o = (src == SRC_AUX);
endmodule

// File: rtl/kbdq_chk.sv
module kbdq_chk #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             kbd_push_i,
  input logic             aux_push_i,
  input logic             avail_o,
  input logic             avail_aux_o,
  input logic [CNT_W-1:0] kbd_cnt,
  input logic [CNT_W-1:0] aux_cnt
);
  // R6
  avail_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o == ((kbd_cnt != '0) || (aux_cnt != '0)));

  // R7
  aux_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_aux_o |-> (kbd_cnt == '0) && (aux_cnt != '0));

  // R3
  replay_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !avail_o && !kbd_push_i && !aux_push_i) |=> $stable(kbd_cnt) && $stable(aux_cnt));

  // R1
  kbd_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && kbd_cnt != '0 && !aux_push_i) |=> $stable(aux_cnt));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kbd_cnt <= CNT_W'(DEPTH)) && (aux_cnt <= CNT_W'(DEPTH)));

  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kbd_cnt == CNT_W'(DEPTH) && kbd_push_i && !rd_i) |=> kbd_cnt == CNT_W'(DEPTH));
endmodule

bind kbd_aux_rx_queue kbdq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .kbd_push_i  (kbd_push_i),
  .aux_push_i  (aux_push_i),
  .avail_o     (avail_o),
  .avail_aux_o (avail_aux_o),
  .kbd_cnt     (kbd_cnt),
  .aux_cnt     (aux_cnt)
);

// File: tb/kbd_aux_rx_queue_test.sv
module kbd_aux_rx_queue_test;
  localparam int DEP = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       kbd_push_i = 1'b0, aux_push_i = 1'b0, rd_i = 1'b0;
  logic [7:0] kbd_data_i = '0, aux_data_i = '0;
  logic [7:0] rd_data_o;
  logic       avail_o, avail_aux_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  byte unsigned q_k[$];
  byte unsigned q_a[$];
  byte unsigned last_k = 8'h00;

  always #5 clk_i = ~clk_i;

  kbd_aux_rx_queue #(.DEPTH(DEP), .DATA_W(8)) uut (
    .clk_i, .rst_ni, .kbd_push_i, .kbd_data_i, .aux_push_i, .aux_data_i,
    .rd_i, .rd_data_o, .avail_o, .avail_aux_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    byte unsigned exp_d;
    string tag;
    if (q_k.size() != 0) begin exp_d = q_k[0]; tag = "R1/R4"; end
    else if (q_a.size() != 0) begin exp_d = q_a[0]; tag = "R2/R4"; end
    else begin exp_d = last_k; tag = "R3"; end
    chk(tag, rd_data_o, exp_d);
    chk("R6", avail_o, (q_k.size() + q_a.size()) != 0);
    chk("R7", avail_aux_o, (q_k.size() == 0) && (q_a.size() != 0));
  endtask

  // model update; R5 full test on pre-edge size, R8 push+pop both apply
  task automatic model_step();
    bit k_full, a_full;
    k_full = q_k.size() >= DEP;
    a_full = q_a.size() >= DEP;
    if (rd_i) begin
      if (q_k.size() != 0) last_k = q_k.pop_front();
      else if (q_a.size() != 0) void'(q_a.pop_front());
    end
    if (kbd_push_i && !k_full) q_k.push_back(kbd_data_i);
    if (aux_push_i && !a_full) q_a.push_back(aux_data_i);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int pk, pa, pr;
    repeat (2) @(negedge clk_i);
    // R9 reset state
    chk("R9", avail_o, 0);
    chk("R9", avail_aux_o, 0);
    chk("R9", rd_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 replay right after reset: slot DEPTH-1 is 0x00
    rd_i = 1'b1;
    @(posedge clk_i); model_step();
    @(negedge clk_i);
    chk("R3", rd_data_o, 0);
    chk("R3", avail_o, 0);
    rd_i = 1'b0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      case ((cyc / 300) % 5)
        0: begin pk = 70; pa = 0;  pr = 10; end  // keyboard fill, R5 drops
        1: begin pk = 0;  pa = 60; pr = 20; end  // aux fill
        2: begin pk = 10; pa = 10; pr = 90; end  // drain, R3 replay
        3: begin pk = 50; pa = 50; pr = 50; end  // mixed, R8
        default: begin pk = 90; pa = 90; pr = 90; end  // saturated
      endcase
      compare_all();
      kbd_push_i = ($urandom % 100) < pk;
      aux_push_i = ($urandom % 100) < pa;
      rd_i       = ($urandom % 100) < pr;
      kbd_data_i = 8'($urandom);
      aux_data_i = 8'($urandom);
      @(posedge clk_i);
      model_step();
      @(negedge clk_i);
    end
    compare_all();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule